// File: doc/BRIEF.md
# In-band channel-select cycle generator

This block sequences payload words from a multi-channel transmitter onto one shared data bus. Before a burst of words for a channel goes out, the bus must say which channel it belongs to. The block does this with a select cycle: the channel number sits on the low bits of the bus, the select strobe is high and data valid is low. The select cycle is inserted in-band, in place of a word slot. While it occupies the bus, ready to the requester is held low.

A configuration input picks the insertion policy. In normal mode, a select cycle is inserted only when the next burst's channel differs from the channel that owns the bus. In always mode, a select cycle is inserted before every burst. Always mode also adds a trailing select cycle, carrying the same channel, right after the last word of any burst that ends a packet. The requester presents words one at a time. The first word of a burst carries the burst's channel, its length (number of words minus one) and an end-of-packet flag. The block adds start and end markers to the output words. It tracks, per channel, whether a packet is open.

Top module: `chansel_seq`

## Requirements
- R1: While reset is held, out_valid, out_sel, out_sop, out_eop and in_ready are all low, and no channel owns the bus.
- R2: A select cycle has out_sel=1 and out_valid=0. It carries the channel number zero-extended on out_data, so all bits above the channel field are 0.
- R3: The first burst after reset is always preceded by a select cycle, whatever the mode.
- R4: With cfg_always=0, a select cycle comes before a burst only if the burst's channel differs from the channel of the previous burst.
- R5: With cfg_always=1, every burst is preceded by a select cycle carrying its channel.
- R6: With cfg_always=1, a burst whose end-of-packet flag is set is followed, in the very next cycle after its last word, by a select cycle carrying that burst's channel.
- R7: in_ready is low in the cycle in which the block decides to issue a select cycle. A word accepted (in_valid and in_ready both high at a clock edge) appears unchanged on out_data with out_valid=1 in the next cycle.
- R8: out_sop marks the first word of a burst on a channel with no open packet. out_eop marks the last word of a burst whose end-of-packet flag is set. Neither marker is ever high on a select cycle.
- R9: in_chan, in_len (word count minus one) and in_eop are sampled only on the first word of a burst. Their values on later words of the same burst have no effect.
- R10: A cycle following one with no accepted word, with no select cycle due, shows out_valid=0 and out_sel=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_always | input | 1 | 1 = select before every burst and after packet end; 0 = only on channel change |
| in_valid | input | 1 | A word is offered |
| in_ready | output | 1 | The offered word is taken at this edge |
| in_data | input | DATA_W | Payload word |
| in_chan | input | CH_W | Burst channel, read on first word |
| in_len | input | LEN_W | Burst word count minus one, read on first word |
| in_eop | input | 1 | Burst ends its packet, read on first word |
| out_data | output | DATA_W | Bus data or channel number on a select cycle |
| out_valid | output | 1 | Bus carries a payload word |
| out_sel | output | 1 | Bus carries a select cycle |
| out_sop | output | 1 | First word of a packet |
| out_eop | output | 1 | Last word of a packet |

## Verification
Every bus output is registered. An accepted word, therefore, appears one cycle after the edge that took it. A select cycle appears one cycle after the edge at which in_ready was held low. A trailing select appears in the cycle right after the burst's last word. For each burst, the bench driver builds the expected sequence of select cycles and words from the mode and its own channel and open-packet model, and queues it. A monitor samples at the falling edge, skips cycles with neither valid nor select, and matches each remaining cycle in order. The driver samples in_ready 1 ns after the falling edge, on the first offer of each burst, to confirm the stall decision. It also checks the idle bus directly after a gap.

// File: rtl/chansel_pkg.sv
package chansel_pkg;
    typedef enum logic [1:0] {
        PH_HDR  = 2'd0,
        PH_DATA = 2'd1,
        PH_TAIL = 2'd2
    } phase_e;
endpackage

// File: rtl/chansel_policy.sv
module chansel_policy #(
    parameter int CH_W = 4
) (
    input  logic            have_ch,
    input  logic [CH_W-1:0] cur_ch,
    input  logic [CH_W-1:0] new_ch,
    input  logic            always_mode,
    output logic            need_sel
);
    // R3/R4/R5: no owner yet, always policy, or channel switch
    always_comb begin
        need_sel = !have_ch || always_mode || (cur_ch != new_ch);
    end
endmodule

// File: rtl/chansel_pkt_track.sv
module chansel_pkt_track #(
    parameter int CH_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CH_W-1:0] rd_ch,
    output logic            in_pkt,
    input  logic            upd,
    input  logic [CH_W-1:0] upd_ch,
    input  logic            upd_val
);
    localparam int NCH = 1 << CH_W;

    logic [NCH-1:0] open_q;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                open_q[c] <= 1'b0;
            end else if (upd && (upd_ch == CH_W'(c))) begin
                open_q[c] <= upd_val;
            end
        end
    end

    assign in_pkt = open_q[rd_ch];
endmodule

// File: rtl/chansel_seq.sv
module chansel_seq #(
    parameter int DATA_W = 32,
    parameter int CH_W   = 4,
    parameter int LEN_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_always,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic [CH_W-1:0]   in_chan,
    input  logic [LEN_W-1:0]  in_len,
    input  logic              in_eop,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    output logic              out_sel,
    output logic              out_sop,
    output logic              out_eop
);
    import chansel_pkg::*;

    typedef struct packed {
        phase_e            phase;
        logic              have_ch;
        logic [CH_W-1:0]   cur_ch;
        logic [LEN_W-1:0]  cnt;
        logic [LEN_W-1:0]  len;
        logic              eop;
        logic              mode;
        logic [DATA_W-1:0] o_data;
        logic              o_valid;
        logic              o_sel;
        logic              o_sop;
        logic              o_eop;
    } st_t;

    st_t st_q, st_d;

    logic             need_sel;
    logic             in_pkt;
    logic             take;
    logic             last;
    logic [CH_W-1:0]  b_ch;
    logic [LEN_W-1:0] b_len;
    logic [LEN_W-1:0] b_cnt;
    logic             b_eop;
    logic             b_mode;

    chansel_policy #(.CH_W(CH_W)) u_policy (
        .have_ch    (st_q.have_ch),
        .cur_ch     (st_q.cur_ch),
        .new_ch     (in_chan),
        .always_mode(cfg_always),
        .need_sel   (need_sel)
    );

    chansel_pkt_track #(.CH_W(CH_W)) u_track (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_ch  (b_ch),
        .in_pkt (in_pkt),
        .upd    (take),
        .upd_ch (b_ch),
        .upd_val(!(last && b_eop))
    );

    // Burst fields: live inputs on a word that starts a burst, latched otherwise (R9)
    always_comb begin
        if (st_q.phase == PH_HDR) begin
            b_ch   = in_chan;
            b_len  = in_len;
            b_cnt  = '0;
            b_eop  = in_eop;
            b_mode = cfg_always;
        end else begin
            b_ch   = st_q.cur_ch;
            b_len  = st_q.len;
            b_cnt  = st_q.cnt;
            b_eop  = st_q.eop;
            b_mode = st_q.mode;
        end
    end

    always_comb begin
        in_ready = (st_q.phase == PH_DATA) || ((st_q.phase == PH_HDR) && !need_sel);
        take     = in_valid && in_ready;
        last     = (b_cnt == b_len);

        st_d         = st_q;
        st_d.o_data  = '0;
        st_d.o_valid = 1'b0;
        st_d.o_sel   = 1'b0;
        st_d.o_sop   = 1'b0;
        st_d.o_eop   = 1'b0;

        if (st_q.phase == PH_TAIL) begin
            // R6: trailing select after a packet end in always mode
            st_d.o_sel  = 1'b1;
            st_d.o_data = DATA_W'(st_q.cur_ch);
            st_d.phase  = PH_HDR;
        end else if ((st_q.phase == PH_HDR) && in_valid && need_sel) begin
            // R2/R7: select cycle, word held back
            st_d.o_sel   = 1'b1;
            st_d.o_data  = DATA_W'(in_chan);
            st_d.have_ch = 1'b1;
            st_d.cur_ch  = in_chan;
            st_d.len     = in_len;
            st_d.eop     = in_eop;
            st_d.mode    = cfg_always;
            st_d.cnt     = '0;
            st_d.phase   = PH_DATA;
        end else if (take) begin
            st_d.o_valid = 1'b1;
            st_d.o_data  = in_data;
            st_d.o_sop   = (b_cnt == '0) && !in_pkt;
            st_d.o_eop   = last && b_eop;
            st_d.have_ch = 1'b1;
            st_d.cur_ch  = b_ch;
            st_d.len     = b_len;
            st_d.eop     = b_eop;
            st_d.mode    = b_mode;
            if (last) begin
                st_d.cnt   = '0;
                st_d.phase = (b_mode && b_eop) ? PH_TAIL : PH_HDR;
            end else begin
                st_d.cnt   = b_cnt + 1'b1;
                st_d.phase = PH_DATA;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_HDR, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign out_data  = st_q.o_data;
    assign out_valid = st_q.o_valid;
    assign out_sel   = st_q.o_sel;
    assign out_sop   = st_q.o_sop;
    assign out_eop   = st_q.o_eop;
endmodule

// File: rtl/chansel_seq_chk.sv
module chansel_seq_chk #(
    parameter int DATA_W = 32,
    parameter int CH_W   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [DATA_W-1:0] out_data,
    input logic              out_valid,
    input logic              out_sel,
    input logic              out_sop,
    input logic              out_eop
);
    logic seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else if (out_sel) seen_q <= 1'b1;
    end

    p_sel_form_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_sel |-> (!out_valid && ((out_data >> CH_W) == '0)));

    p_first_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> seen_q);

    p_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_sel |-> $past(!in_ready));

    p_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    p_marks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sop || out_eop) |-> (out_valid && !out_sel));
endmodule

bind chansel_seq chansel_seq_chk #(.DATA_W(DATA_W), .CH_W(CH_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .out_data (out_data),
    .out_valid(out_valid),
    .out_sel  (out_sel),
    .out_sop  (out_sop),
    .out_eop  (out_eop)
);

// File: tb/test_chansel_seq.sv
`timescale 1ns/1ps
module test_chansel_seq;
    localparam int DW = 32;
    localparam int CW = 4;
    localparam int LW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_always = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [DW-1:0] in_data = '0;
    logic [CW-1:0] in_chan = '0;
    logic [LW-1:0] in_len = '0;
    logic          in_eop = 1'b0;
    logic [DW-1:0] out_data;
    logic          out_valid, out_sel, out_sop, out_eop;

    always #2.5 clk = ~clk;

    chansel_seq #(.DATA_W(DW), .CH_W(CW), .LEN_W(LW)) i_chansel_seq (
        .clk(clk), .rst_n(rst_n), .cfg_always(cfg_always),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_chan(in_chan), .in_len(in_len), .in_eop(in_eop),
        .out_data(out_data), .out_valid(out_valid), .out_sel(out_sel),
        .out_sop(out_sop), .out_eop(out_eop)
    );

    typedef struct {
        bit            sel;
        logic [DW-1:0] data;
        bit            sop;
        bit            eop;
        string         tag;
    } exp_t;

    exp_t          sb[$];
    int            total = 0;
    int            bad = 0;
    bit            m_have = 0;
    logic [CW-1:0] m_cur = '0;
    bit            m_open [16];
    int            burst_id = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Monitor: compare each non-idle bus cycle with the next expected item
    exp_t e;
    always @(negedge clk) begin
        if (rst_n && (out_valid || out_sel)) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R10", "unexpected bus cycle",
                    {28'h0, out_sel, out_valid, out_sop, out_eop, out_data}, 64'h0);
            end else begin
                e = sb.pop_front();
                chk(out_sel == e.sel && out_valid == !e.sel && out_data == e.data &&
                    out_sop == e.sop && out_eop == e.eop, e.tag, "bus cycle",
                    {28'h0, out_sel, out_valid, out_sop, out_eop, out_data},
                    {28'h0, e.sel, !e.sel, e.sop, e.eop, e.data});
            end
        end
    end

    function automatic logic [DW-1:0] word_of(input int id, input int idx);
        return DW'((id << 16) | (idx << 4) | 32'hA);
    endfunction

    task automatic burst(input logic [CW-1:0] ch, input int n, input bit eop, input bit gap);
        bit    need;
        bit    r;
        bit    first;
        string stag;
        need = !m_have || cfg_always || (ch != m_cur);
        stag = cfg_always ? "R5" : (m_have ? "R4" : "R3");
        burst_id++;
        if (need) sb.push_back('{1'b1, DW'(ch), 1'b0, 1'b0, stag});
        for (int i = 0; i < n; i++) begin
            sb.push_back('{1'b0, word_of(burst_id, i), (i == 0) && !m_open[ch],
                           (i == n - 1) && eop, "R8"});
        end
        if (cfg_always && eop) sb.push_back('{1'b1, DW'(ch), 1'b0, 1'b0, "R6"});
        m_have = 1;
        m_cur = ch;
        m_open[ch] = !eop;

        for (int i = 0; i < n; i++) begin
            in_valid = 1'b1;
            in_data = word_of(burst_id, i);
            if (i == 0) begin
                in_chan = ch;
                in_len = LW'(n - 1);
                in_eop = eop;
            end else begin
                // R9: junk header fields on later words
                in_chan = ~ch;
                in_len = ~LW'(n - 1);
                in_eop = !eop;
            end
            first = 1;
            do begin
                #1 r = in_ready;
                if (first && i == 0) chk(r == !need, "R7", "ready on first offer", 64'(r), 64'(!need));
                first = 0;
                @(negedge clk);
            end while (!r);
            if (gap && (i % 2 == 0)) begin
                in_valid = 1'b0;
                @(negedge clk);
            end
        end
        in_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!out_valid && !out_sel && !out_sop && !out_eop, "R1", "outputs in reset",
            {60'h0, out_valid, out_sel, out_sop, out_eop}, 64'h0);
        chk(!in_ready, "R1", "ready in reset", 64'(in_ready), 64'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!out_valid && !out_sel, "R10", "idle after reset", {62'h0, out_valid, out_sel}, 64'h0);

        // Normal mode
        cfg_always = 1'b0;
        burst(4'd3, 2, 1'b0, 1'b0);   // R3 first select
        burst(4'd3, 3, 1'b1, 1'b1);   // R4 no select, R9 junk fields
        // R10: idle bus one cycle after the gap
        chk(!out_valid && !out_sel, "R10", "idle after gap", {62'h0, out_valid, out_sel}, 64'h0);
        burst(4'd5, 1, 1'b1, 1'b0);   // R4 switch, sop+eop on one word
        burst(4'd3, 4, 1'b0, 1'b0);   // R4 switch back
        burst(4'd15, 2, 1'b1, 1'b0);  // R2 widest channel

        // Always mode
        cfg_always = 1'b1;
        burst(4'd15, 2, 1'b0, 1'b0);  // R5 same channel still selected
        burst(4'd15, 2, 1'b1, 1'b1);  // R6 tail select
        burst(4'd7, 1, 1'b1, 1'b0);   // R5 and R6
        burst(4'd3, 3, 1'b1, 1'b0);   // R8 closes open packet on channel 3

        // Back to normal
        cfg_always = 1'b0;
        burst(4'd3, 2, 1'b1, 1'b0);   // R4 no select after the tail
        burst(4'd0, 16, 1'b1, 1'b1);  // R9 maximum length

        for (int k = 0; k < 40 && sb.size() != 0; k++) @(negedge clk);
        chk(sb.size() == 0, "R5", "all expected cycles seen", 64'(sb.size()), 64'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R7 watchdog expired actual=%0d expected=%0d", 20000, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule